// File: doc/BRIEF.md
# Flash program/erase status controller

This block runs the write-side operations of a small behavioural flash array and keeps the status byte that reports how those operations ended. A single-cycle command strobe carries an opcode, a word address and a data word. The block can program one word, erase a block of words, check that a block is blank, or clear the error bits. Program and erase run as a loop: one pulse, then a verify. The loop repeats until verify passes or a parameterised pulse limit is reached.

Failures are reported through three sticky error bits. One covers erase and blank check, one covers program, and one records a missing supply. While a relevant bit is set, a new command of that kind is refused without touching the array. The supply-valid input is looked at only in the cycle a program or erase is accepted. A test input forces verify to fail, so that the pulse-limit path can be reached. A read port gives direct access to the array contents.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 and every array word reads FFFFh.
- R2: Opcode 2'b01 (program) writes old AND data into the addressed word. When the first verify passes, ready (status bit 7) is low for exactly 2 cycles.
- R3: Opcode 2'b10 (erase) sets all 8 words of the block selected by address bits [5:3] to FFFFh. When the first verify passes, ready is low for exactly 2 cycles.
- R4: Opcode 2'b11 (blank check) holds ready low for 1 cycle. It sets status bit 5 if any word of the addressed block differs from FFFFh, and otherwise leaves the status unchanged.
- R5: If verify keeps failing during a program, status bit 4 is set after MAX_PULSES pulses, and ready is low for 2*MAX_PULSES cycles (16 by default).
- R6: If verify keeps failing during an erase, status bit 5 is set after MAX_PULSES pulses, and ready is low for 2*MAX_PULSES cycles.
- R7: If supply_ok is low when a program or erase is accepted, status bit 3 is set, the array is not changed, and ready is low for 1 cycle.
- R8: supply_ok is ignored after the accepting cycle. Dropping it during an operation does not change the outcome.
- R9: Error bits 5, 4 and 3 stay set until opcode 2'b00 (clear) is accepted or a reset occurs. Clear resets all three in the accepting cycle and leaves ready high.
- R10: A program is refused while bit 4 or bit 3 is set. An erase is refused while bit 5 or bit 3 is set. A refused command leaves the array unchanged and holds ready low for 1 cycle.
- R11: A command strobe while ready is low is ignored.
- R12: Status layout: bit 7 ready, bit 5 erase/blank error, bit 4 program error, bit 3 supply lockout. Bits 6, 2, 1 and 0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted only while ready |
| cmd_op | input | 2 | 00 clear, 01 program, 10 erase, 11 blank check |
| cmd_addr | input | ADDR_W | Word address; upper bits select the block |
| cmd_data | input | DATA_W | Program data |
| supply_ok | input | 1 | Supply-valid indication |
| verify_fail_inject | input | 1 | Test hook forcing verify to fail |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at rd_addr |
| status | output | 8 | Status byte |

## Verification
Program is tried with data that clears a few bits of an erased word, and again with data that would set bits. The second case tells AND-merging apart from plain overwrite. Erase and blank check are tried on dirty and clean blocks, which separates a real block scan from a constant result. Every error path is driven with each error bit set alone and then combined. This shows which bit blocks which opcode, and that blank check is not itself blocked. The ready-low cycle count on every vector tells apart a pass on the first pulse, a run to the pulse limit, and an immediate refusal.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR   = 2'b00,
        OP_PROGRAM = 2'b01,
        OP_ERASE   = 2'b10,
        OP_BLANK   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_VERIFY,
        ST_BLANK,
        ST_REJECT
    } state_e;

    localparam int STAT_READY = 7;
    localparam int STAT_ERASE = 5;
    localparam int STAT_PROG  = 4;
    localparam int STAT_LOCK  = 3;
endpackage

// File: rtl/flash_pe_array.sv
`timescale 1ns/1ps
module flash_pe_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ers_en,
    output logic [DATA_W-1:0] op_rdata,
    output logic              blk_blank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BLK_WORDS = 1 << BLK_W;
    localparam int SEL_W     = ADDR_W - BLK_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [SEL_W-1:0]  blk_sel;

    assign blk_sel  = op_addr[ADDR_W-1:BLK_W];
    assign op_rdata = mem_q[op_addr];
    assign rd_data  = mem_q[rd_addr];

    always_comb begin
        blk_blank = 1'b1;
        for (int i = 0; i < BLK_WORDS; i++) begin
            if (mem_q[{blk_sel, BLK_W'(i)}] != {DATA_W{1'b1}}) begin
                blk_blank = 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[op_addr] = wr_data;
        end
        if (ers_en) begin
            for (int i = 0; i < BLK_WORDS; i++) begin
                mem_d[{blk_sel, BLK_W'(i)}] = {DATA_W{1'b1}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= {DATA_W{1'b1}};
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // R2: a program pulse may only clear bits of the stored word
    a_r2_only_clears_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~mem_q[op_addr]) == '0));

    // R3: after an erase pulse the pulsed block reads blank
    a_r3_erase_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_en && !wr_en) ##1 $stable(blk_sel) |-> blk_blank);
endmodule

// File: rtl/flash_pe_status.sv
`timescale 1ns/1ps
module flash_pe_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_erase,
    input  logic set_prog,
    input  logic set_lock,
    output logic erase_err,
    output logic prog_err,
    output logic lock_err
);
    typedef struct packed {
        logic erase;
        logic prog;
        logic lock;
    } err_t;

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr) begin
            err_d = '0;
        end
        if (set_erase) err_d.erase = 1'b1;
        if (set_prog)  err_d.prog  = 1'b1;
        if (set_lock)  err_d.lock  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign erase_err = err_q.erase;
    assign prog_err  = err_q.prog;
    assign lock_err  = err_q.lock;

    // R9: error bits are sticky until a clear
    a_r9_erase_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_err && !clr) |=> erase_err);
    a_r9_prog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !clr) |=> prog_err);
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && !clr) |=> lock_err);
endmodule

// File: rtl/flash_pe_ctrl.sv
`timescale 1ns/1ps
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int BLK_W      = 3,
    parameter int MAX_PULSES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              supply_ok,
    input  logic              verify_fail_inject,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);
    localparam int CNT_W = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        state_e            state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] target;
        logic [CNT_W-1:0]  pulses;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic              ready;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_rdata;
    logic              blk_blank;
    logic              wr_en, ers_en;
    logic              clr, set_erase, set_prog, set_lock;
    logic              erase_err, prog_err, lock_err;
    logic              verify_ok;
    op_e               cmd_kind;

    assign ready    = (ctrl_q.state == ST_IDLE);
    assign op_addr  = ready ? cmd_addr : ctrl_q.addr;
    assign cmd_kind = op_e'(cmd_op);

    flash_pe_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BLK_W  (BLK_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_addr   (op_addr),
        .wr_en     (wr_en),
        .wr_data   (ctrl_q.target),
        .ers_en    (ers_en),
        .op_rdata  (op_rdata),
        .blk_blank (blk_blank),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    flash_pe_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .set_erase (set_erase),
        .set_prog  (set_prog),
        .set_lock  (set_lock),
        .erase_err (erase_err),
        .prog_err  (prog_err),
        .lock_err  (lock_err)
    );

    always_comb begin
        if (ctrl_q.op == OP_PROGRAM) verify_ok = (op_rdata == ctrl_q.target);
        else                         verify_ok = blk_blank;
        verify_ok = verify_ok && !verify_fail_inject;
    end

    always_comb begin
        ctrl_d    = ctrl_q;
        wr_en     = 1'b0;
        ers_en    = 1'b0;
        clr       = 1'b0;
        set_erase = 1'b0;
        set_prog  = 1'b0;
        set_lock  = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctrl_d.op     = cmd_kind;
                    ctrl_d.addr   = cmd_addr;
                    ctrl_d.pulses = '0;
                    case (cmd_kind)
                        OP_CLEAR: begin
                            clr = 1'b1;
                        end
                        OP_PROGRAM: begin
                            ctrl_d.target = op_rdata & cmd_data;
                            if (lock_err || prog_err) begin
                                ctrl_d.state = ST_REJECT;
                            end else if (!supply_ok) begin
                                set_lock     = 1'b1;
                                ctrl_d.state = ST_REJECT;
                            end else begin
                                ctrl_d.state = ST_PULSE;
                            end
                        end
                        OP_ERASE: begin
                            ctrl_d.target = {DATA_W{1'b1}};
                            if (lock_err || erase_err) begin
                                ctrl_d.state = ST_REJECT;
                            end else if (!supply_ok) begin
                                set_lock     = 1'b1;
                                ctrl_d.state = ST_REJECT;
                            end else begin
                                ctrl_d.state = ST_PULSE;
                            end
                        end
                        default: begin
                            ctrl_d.state = ST_BLANK;
                        end
                    endcase
                end
            end
            ST_PULSE: begin
                if (ctrl_q.op == OP_PROGRAM) wr_en = 1'b1;
                else                         ers_en = 1'b1;
                ctrl_d.pulses = ctrl_q.pulses + 1'b1;
                ctrl_d.state  = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (verify_ok) begin
                    ctrl_d.state = ST_IDLE;
                end else if (ctrl_q.pulses >= CNT_W'(MAX_PULSES)) begin
                    if (ctrl_q.op == OP_PROGRAM) set_prog = 1'b1;
                    else                         set_erase = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end else begin
                    ctrl_d.state = ST_PULSE;
                end
            end
            ST_BLANK: begin
                if (!blk_blank) set_erase = 1'b1;
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_IDLE;
            ctrl_q.op    <= OP_CLEAR;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        status                   = 8'h00;
        status[STAT_READY]       = ready;
        status[STAT_ERASE]       = erase_err;
        status[STAT_PROG]        = prog_err;
        status[STAT_LOCK]        = lock_err;
    end

    // R11: an accepted non-clear command drops ready on the next cycle
    a_r11_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_valid && cmd_op != 2'b00) |=> !status[7]);

    // R11: the latched command is not disturbed while busy
    a_r11_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(ctrl_q.addr));

    // R5: a program error only follows the last allowed pulse
    a_r5_prog_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> $past(ctrl_q.pulses) == CNT_W'(MAX_PULSES));

    // R5 / R6: pulse count never runs past the limit
    a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.pulses <= CNT_W'(MAX_PULSES));

    // R7: lockout only rises after a low supply at acceptance
    a_r7_lock_from_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |-> $past(!supply_ok && cmd_valid));

    // R12: unused status bits read zero
    a_r12_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'h47) == 8'h00);
endmodule

// File: tb/flash_pe_ctrl_bench.sv
`timescale 1ns/1ps
module flash_pe_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        supply_ok = 1'b1;
    logic        verify_fail_inject = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    flash_pe_ctrl u_flash_pe_ctrl (
        .clk                (clk),
        .rst_n              (rst_n),
        .cmd_valid          (cmd_valid),
        .cmd_op             (cmd_op),
        .cmd_addr           (cmd_addr),
        .cmd_data           (cmd_data),
        .supply_ok          (supply_ok),
        .verify_fail_inject (verify_fail_inject),
        .rd_addr            (rd_addr),
        .rd_data            (rd_data),
        .status             (status)
    );

    // fields: req[64:61] op[60:59] addr[58:53] data[52:37] sup[36] inj[35]
    //         busy[34:30] status[29:22] chk_addr[21:16] word[15:0]
    localparam int NV = 18;
    localparam logic [64:0] VEC [NV] = '{
        {4'd2,  2'd1, 6'd5,  16'h1234, 1'b1, 1'b0, 5'd2,  8'h80, 6'd5,  16'h1234}, // R2
        {4'd2,  2'd1, 6'd5,  16'hFF0F, 1'b1, 1'b0, 5'd2,  8'h80, 6'd5,  16'h1204}, // R2 AND merge
        {4'd4,  2'd3, 6'd0,  16'h0000, 1'b1, 1'b0, 5'd1,  8'hA0, 6'd5,  16'h1204}, // R4 dirty
        {4'd9,  2'd0, 6'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  8'h80, 6'd5,  16'h1204}, // R9 clear
        {4'd3,  2'd2, 6'd3,  16'h0000, 1'b1, 1'b0, 5'd2,  8'h80, 6'd5,  16'hFFFF}, // R3
        {4'd4,  2'd3, 6'd7,  16'h0000, 1'b1, 1'b0, 5'd1,  8'h80, 6'd5,  16'hFFFF}, // R4 clean
        {4'd7,  2'd1, 6'd9,  16'h00F0, 1'b0, 1'b0, 5'd1,  8'h88, 6'd9,  16'hFFFF}, // R7
        {4'd10, 2'd2, 6'd9,  16'h0000, 1'b1, 1'b0, 5'd1,  8'h88, 6'd9,  16'hFFFF}, // R10 lock blocks erase
        {4'd9,  2'd0, 6'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  8'h80, 6'd9,  16'hFFFF}, // R9
        {4'd5,  2'd1, 6'd9,  16'h0F0F, 1'b1, 1'b1, 5'd16, 8'h90, 6'd9,  16'h0F0F}, // R5
        {4'd10, 2'd1, 6'd10, 16'h0000, 1'b1, 1'b0, 5'd1,  8'h90, 6'd10, 16'hFFFF}, // R10 prog blocked
        {4'd6,  2'd2, 6'd8,  16'h0000, 1'b1, 1'b1, 5'd16, 8'hB0, 6'd9,  16'hFFFF}, // R6
        {4'd9,  2'd0, 6'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  8'h80, 6'd9,  16'hFFFF}, // R9
        {4'd2,  2'd1, 6'd20, 16'h0000, 1'b1, 1'b0, 5'd2,  8'h80, 6'd20, 16'h0000}, // R2
        {4'd4,  2'd3, 6'd16, 16'h0000, 1'b1, 1'b0, 5'd1,  8'hA0, 6'd20, 16'h0000}, // R4
        {4'd10, 2'd2, 6'd16, 16'h0000, 1'b1, 1'b0, 5'd1,  8'hA0, 6'd20, 16'h0000}, // R10 erase blocked
        {4'd10, 2'd1, 6'd21, 16'hAAAA, 1'b1, 1'b0, 5'd2,  8'hA0, 6'd21, 16'hAAAA}, // R10 prog allowed
        {4'd12, 2'd0, 6'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  8'h80, 6'd21, 16'hAAAA}  // R12
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ready(output int busy);
        busy = 0;
        while (!status[7] && busy < 200) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [5:0] addr,
                         input logic [15:0] data, input logic sup,
                         input logic inj, output int busy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        supply_ok = sup; verify_fail_inject = inj;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_ready(busy);
        verify_fail_inject = 1'b0;
        supply_ok = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int busy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "reset status", {24'd0, status}, 32'h80);
        rd_addr = 6'd0;  #1 check(1, "reset word 0", {16'd0, rd_data}, 32'hFFFF);
        rd_addr = 6'd63; #1 check(1, "reset word 63", {16'd0, rd_data}, 32'hFFFF);

        for (int v = 0; v < NV; v++) begin
            logic [64:0] e;
            e = VEC[v];
            issue(e[60:59], e[58:53], e[52:37], e[36], e[35], busy);
            check(int'(e[64:61]), $sformatf("vec %0d busy", v), busy, {27'd0, e[34:30]});
            check(int'(e[64:61]), $sformatf("vec %0d status", v), {24'd0, status}, {24'd0, e[29:22]});
            rd_addr = e[21:16];
            #1 check(int'(e[64:61]), $sformatf("vec %0d word", v), {16'd0, rd_data}, {16'd0, e[15:0]});
        end

        // R11: strobe during busy ignored (erase of same block would restore FFFF)
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 6'd30; cmd_data = 16'h00FF;
        @(negedge clk);
        cmd_op = 2'b10; cmd_addr = 6'd30;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_ready(busy);
        rd_addr = 6'd30;
        #1 check(11, "busy strobe ignored word", {16'd0, rd_data}, 32'h00FF);
        check(11, "busy strobe ignored status", {24'd0, status}, 32'h80);

        // R8: supply dropped after acceptance has no effect
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 6'd40; cmd_data = 16'h0F00; supply_ok = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; supply_ok = 1'b0;
        wait_ready(busy);
        supply_ok = 1'b1;
        check(8, "supply drop busy", busy, 32'd2);
        check(8, "supply drop status", {24'd0, status}, 32'h80);
        rd_addr = 6'd40;
        #1 check(8, "supply drop word", {16'd0, rd_data}, 32'h0F00);

        // R7 / R10: lockout blocks erase and program
        issue(2'b10, 6'd40, 16'h0, 1'b0, 1'b0, busy);
        check(7, "erase lockout status", {24'd0, status}, 32'h88);
        rd_addr = 6'd40;
        #1 check(7, "erase lockout word", {16'd0, rd_data}, 32'h0F00);
        issue(2'b01, 6'd40, 16'h0000, 1'b1, 1'b0, busy);
        #1 check(10, "program blocked by lockout", {16'd0, rd_data}, 32'h0F00);

        // R1: reset clears sticky bits
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "reset clears errors", {24'd0, status}, 32'h80);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule